// File: doc/BRIEF.md
# Daisy-Chain Bus Arbiter

This block decides which of several devices on one shared bus becomes master. Each device can raise its request line. It carries a level field that places it on one of several priority levels. Each level has its own wired-OR request line. When the bus is idle, the arbiter drives a grant on the most urgent level that has a request. That grant then passes down a chain of devices in index order. The first requesting device on that level keeps the grant. Every device before it passes the grant on unchanged.

The device that keeps the grant becomes owner and raises the shared busy line. It holds busy for a number of cycles taken from its own length field. While busy is high the arbiter keeps every grant low. It looks at the requests again on the first cycle after busy falls. The grant is a one-cycle registered pulse, and the ripple through the chain settles within that cycle.

Top module: `chain_bus_arbiter`

## Requirements
- R1: Out of reset, grant_o, busy_o and owner_o are all zero.
- R2: lvl_req_o[l] is high exactly when some device requests and its level field lvl_i[i*LW +: LW] equals l. A level field value of N_LVL or above joins no level.
- R3: Suppose the bus is idle with no grant pending and at least one level has a request. Then on the next edge grant_o becomes one-hot on the lowest-numbered requesting level, where level 0 is the most urgent.
- R4: grant_o stays high for one cycle only and is never high while busy_o is high.
- R5: While a level's grant is high, the lowest-indexed device requesting on that level absorbs it. On the next edge owner_o becomes one-hot on that device and busy_o rises.
- R6: A device requesting on a level other than the granted one never takes the grant. If no device on the granted level is still requesting, the grant lapses with busy_o low, and arbitration runs again on the following edge.
- R7: owner_o has at most one bit set, and busy_o is high exactly when owner_o is nonzero.
- R8: busy_o stays high for exactly the winner's length field len_i[i*LEN_W +: LEN_W] cycles, a value of 0 counting as 1. owner_o does not change during that time.
- R9: After busy_o falls, one idle cycle passes with grant_o low. On the edge after that idle cycle, a grant is issued if any requests are present.
- R10: Requests raised while the bus is busy do not change the owner, even from lower-indexed devices or devices on more urgent levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_DEV | Per-device bus request |
| lvl_i | input | N_DEV*LW | Per-device priority level field |
| len_i | input | N_DEV*LEN_W | Per-device transfer length in cycles |
| lvl_req_o | output | N_LVL | Wired-OR request line of each level |
| grant_o | output | N_LVL | Registered grant driven into each level's chain |
| busy_o | output | 1 | Shared busy line |
| owner_o | output | N_DEV | One-hot current bus master |

## Verification
The faults that matter show up within two edges of a request. A chain that forwards a grant it should keep would put the wrong device, or no device, on owner_o one edge after grant_o pulses. A wrong level select would put grant_o on the wrong bit one edge after requests appear. A faulty length counter would make busy_o fall early or late, and that shows in the count of busy cycles. A faulty release path would move the next grant off its single idle cycle, or let a waiting request take the bus while it is still busy.

// File: rtl/chain_bus_arbiter.sv
module chain_bus_arbiter #(
  parameter int N_DEV = 6,
  parameter int N_LVL = 3,
  parameter int LEN_W = 4,
  localparam int LW = (N_LVL > 1) ? $clog2(N_LVL) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_DEV-1:0]       req_i,
  input  logic [N_DEV*LW-1:0]    lvl_i,
  input  logic [N_DEV*LEN_W-1:0] len_i,
  output logic [N_LVL-1:0]       lvl_req_o,
  output logic [N_LVL-1:0]       grant_o,
  output logic                   busy_o,
  output logic [N_DEV-1:0]       owner_o
);

  logic [N_LVL-1:0]            g_q, g_next;
  logic                        busy_q;
  logic [N_DEV-1:0]            owner_q, win;
  logic [LEN_W-1:0]            cnt_q, wlen;
  logic [N_LVL-1:0][N_DEV-1:0] take;

  for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
    logic [N_DEV-1:0] hit;
    logic [N_DEV-1:0] chn;
    assign chn[0] = g_q[l];
    for (genvar i = 0; i < N_DEV; i++) begin : g_dev
      assign hit[i] = req_i[i] && (lvl_i[i*LW +: LW] == LW'(l));
      if (i + 1 < N_DEV) begin : g_pass
        assign chn[i+1] = chn[i] & ~hit[i];
      end
    end
    assign take[l]      = hit & chn;
    assign lvl_req_o[l] = |hit;
  end

  always_comb begin
    win = '0;
    for (int l = 0; l < N_LVL; l++) win = win | take[l];
  end

  always_comb begin
    wlen = '0;
    for (int i = 0; i < N_DEV; i++)
      if (win[i]) wlen = len_i[i*LEN_W +: LEN_W];
  end

  always_comb begin
    logic found;
    found  = 1'b0;
    g_next = '0;
    for (int l = 0; l < N_LVL; l++)
      if (!found && lvl_req_o[l]) begin
        g_next[l] = 1'b1;
        found     = 1'b1;
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g_q     <= '0;
      busy_q  <= 1'b0;
      owner_q <= '0;
      cnt_q   <= '0;
    end else if (busy_q) begin
      g_q <= '0;
      if (cnt_q == LEN_W'(1)) begin
        busy_q  <= 1'b0;
        owner_q <= '0;
      end else begin
        cnt_q <= cnt_q - LEN_W'(1);
      end
    end else if (|g_q) begin
      g_q <= '0;
      if (|win) begin
        busy_q  <= 1'b1;
        owner_q <= win;
        cnt_q   <= (wlen == '0) ? LEN_W'(1) : wlen;
      end
    end else begin
      g_q <= g_next;
    end
  end

  assign grant_o = g_q;
  assign busy_o  = busy_q;
  assign owner_o = owner_q;

  p_owner_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owner_q));
  p_busy_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q == (owner_q != '0));
  p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(g_q));
  p_no_grant_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (g_q == '0));
  p_grant_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|g_q) |=> (g_q == '0));
  p_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(g_q & lvl_req_o)) |=> busy_q);
  p_lapse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|g_q) && !(|(g_q & lvl_req_o))) |=> !busy_q);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != LEN_W'(1)) |=> (busy_q && $stable(owner_q)));
  p_rearb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && g_q == '0 && (|lvl_req_o)) |=> (|g_q));

endmodule

// File: tb/tb_chain_bus_arbiter.sv
`timescale 1ns/1ps
module tb_chain_bus_arbiter;
  localparam int N_DEV = 6;
  localparam int N_LVL = 3;
  localparam int LEN_W = 4;
  localparam int LW    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_DEV-1:0]       req = '0;
  logic [N_DEV*LW-1:0]    lvl = '0;
  logic [N_DEV*LEN_W-1:0] len = '0;
  logic [N_LVL-1:0]       lvl_req_o, grant_o;
  logic                   busy_o;
  logic [N_DEV-1:0]       owner_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  chain_bus_arbiter #(.N_DEV(N_DEV), .N_LVL(N_LVL), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .lvl_i(lvl), .len_i(len),
    .lvl_req_o(lvl_req_o), .grant_o(grant_o), .busy_o(busy_o), .owner_o(owner_o));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_dev(input int i, input int l, input int n);
    lvl[i*LW +: LW]       = LW'(l);
    len[i*LEN_W +: LEN_W] = LEN_W'(n);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 40 && busy_o; k++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_arb(input string tag, input logic [N_DEV-1:0] r, input int el, input int ed, input int elen);
    int  cyc;
    bit  stable_ok, nogrant_ok;
    req = r;
    @(negedge clk);
    check(grant_o == N_LVL'(1 << el), {tag, " R3 grant level"}, grant_o, 1 << el);
    check(!busy_o, {tag, " R4 idle at grant"}, busy_o, 0);
    @(negedge clk);
    check(owner_o == N_DEV'(1 << ed), {tag, " R5 owner"}, owner_o, 1 << ed);
    check(busy_o, {tag, " R5 busy rises"}, busy_o, 1);
    check(grant_o == '0, {tag, " R4 grant pulse"}, grant_o, 0);
    req = '0;
    cyc = 1; stable_ok = 1; nogrant_ok = 1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!busy_o) break;
      cyc++;
      if (owner_o != N_DEV'(1 << ed)) stable_ok = 0;
      if (grant_o != '0) nogrant_ok = 0;
    end
    check(cyc == elen, {tag, " R8 busy length"}, cyc, elen);
    check(stable_ok, {tag, " R8 owner stable"}, stable_ok, 1);
    check(nogrant_ok, {tag, " R4 no grant while busy"}, nogrant_ok, 1);
    check(owner_o == '0, {tag, " R7 owner clears with busy"}, owner_o, 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(grant_o == '0, "R1 grant", grant_o, 0);
    check(!busy_o, "R1 busy", busy_o, 0);
    check(owner_o == '0, "R1 owner", owner_o, 0);
  endtask

  task automatic t_level_lines();
    for (int i = 0; i < N_DEV; i++) set_dev(i, i % 3, 2);
    set_dev(5, 3, 2);
    req = 6'b000010; #1;
    check(lvl_req_o == 3'b010, "R2 single level", lvl_req_o, 3'b010);
    req = 6'b001101; #1;
    check(lvl_req_o == 3'b101, "R2 two levels", lvl_req_o, 3'b101);
    req = 6'b100000; #1;
    check(lvl_req_o == 3'b000, "R2 out of range level", lvl_req_o, 0);
    req = '0;
    @(negedge clk);
  endtask

  task automatic t_out_of_range();
    bit quiet;
    set_dev(2, 3, 2);
    req = 6'b000100;
    quiet = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (grant_o != '0 || busy_o) quiet = 0;
    end
    check(quiet, "R6 unlevelled request never served", quiet, 1);
    req = '0;
    @(negedge clk);
  endtask

  task automatic t_same_level();
    for (int i = 0; i < N_DEV; i++) set_dev(i, 0, 2);
    set_dev(2, 0, 3);
    run_arb("same-level", 6'b101100, 0, 2, 3);
    set_dev(4, 0, 0);
    run_arb("len-zero", 6'b110000, 0, 4, 1);
    run_arb("all-request", 6'b111111, 0, 0, 2);
  endtask

  task automatic t_multi_level();
    for (int i = 0; i < N_DEV; i++) set_dev(i, 2, 2);
    set_dev(0, 2, 2); set_dev(1, 1, 2); set_dev(3, 1, 15); set_dev(5, 1, 2);
    run_arb("level-pick", 6'b101001, 1, 3, 15);
    run_arb("lowest-level-only", 6'b000001, 2, 0, 2);
  endtask

  task automatic t_lapse();
    for (int i = 0; i < N_DEV; i++) set_dev(i, 2, 2);
    set_dev(1, 0, 2); set_dev(3, 1, 2);
    req = 6'b001010;
    @(negedge clk);
    check(grant_o == 3'b001, "R3 level 0 granted", grant_o, 3'b001);
    req = 6'b001000;
    @(negedge clk);
    check(!busy_o, "R6 lapse busy low", busy_o, 0);
    check(owner_o == '0, "R6 other level does not take", owner_o, 0);
    @(negedge clk);
    check(grant_o == 3'b010, "R6 re-arbitration", grant_o, 3'b010);
    @(negedge clk);
    check(owner_o == 6'b001000, "R6 later winner", owner_o, 6'b001000);
    req = '0;
    wait_idle();
  endtask

  task automatic t_busy_requests();
    bit kept;
    for (int i = 0; i < N_DEV; i++) set_dev(i, 2, 2);
    set_dev(4, 1, 3); set_dev(1, 0, 2);
    req = 6'b010000;
    @(negedge clk); @(negedge clk);
    check(owner_o == 6'b010000, "R5 owner before intrusion", owner_o, 6'b010000);
    req = 6'b000010;
    kept = 1;
    @(negedge clk);
    if (owner_o != 6'b010000 || !busy_o) kept = 0;
    @(negedge clk);
    if (owner_o != 6'b010000 || !busy_o) kept = 0;
    check(kept, "R10 owner kept against urgent request", kept, 1);
    @(negedge clk);
    check(!busy_o, "R9 busy fell", busy_o, 0);
    check(grant_o == '0, "R9 idle cycle no grant", grant_o, 0);
    @(negedge clk);
    check(grant_o == 3'b001, "R9 grant after idle cycle", grant_o, 3'b001);
    @(negedge clk);
    check(owner_o == 6'b000010, "R9 waiting device wins", owner_o, 6'b000010);
    req = '0;
    wait_idle();
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_level_lines();
    t_out_of_range();
    t_same_level();
    t_multi_level();
    t_lapse();
    t_busy_requests();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule